// File: doc/BRIEF.md
# Procedure Stack Frame Unit

This block keeps the stack pointer and the frame pointer of a processor and performs the memory traffic of the stack operations in hardware. The stack sits in a word-addressed memory reached through one single-port interface, and it grows toward lower addresses. A command is issued with a valid/ready handshake together with two operands. While the unit works through the memory cycles of that command it holds ready low. The commands are push, pop, call, enter, leave and return.

Call stores the return address on the stack and redirects the next-PC output to the target. Enter builds a frame in three steps: it stores the caller's frame pointer, copies the stack pointer into the frame pointer, and then reserves the requested number of local words. Leave unwinds a frame through the saved link. Return performs a leave and then pops the return address into next-PC. Because every frame holds its return point and the frame pointer of the previous frame, nested and recursive frames form a chain that unwinds in the right order. Two limit inputs bound the stack region. A command that would cross either limit is refused, and it sets a sticky error flag.

Top module: `frame_stack_unit`

## Requirements
- R1: After reset, sp and fp both equal the TOP parameter (default 240), next_pc and pop_data are 0, err is 0 and cmd_ready is 1.
- R2: PUSH (cmd_op 0) decrements sp first and then writes cmd_a at the new sp. It holds cmd_ready low for exactly 1 cycle after acceptance.
- R3: POP (cmd_op 1) reads the word at sp into pop_data and then increments sp, returning words in last-in first-out order. Memory read data arrives the cycle after the request. The command holds cmd_ready low for 2 cycles.
- R4: CALL (cmd_op 2) decrements sp, writes the return address cmd_b at the new sp and sets next_pc to the target cmd_a. It holds cmd_ready low for 1 cycle.
- R5: ENTER (cmd_op 3) with size cmd_a[AW-1:0] writes fp at sp-1, sets fp to sp-1 and then sets sp to sp-1-size. It holds cmd_ready low for 2 cycles.
- R6: LEAVE (cmd_op 4) sets sp to fp+1 and reloads fp from the word stored at the old fp. It holds cmd_ready low for 2 cycles.
- R7: RET (cmd_op 5) performs the LEAVE sequence and then pops the word at the restored sp into next_pc, incrementing sp. It holds cmd_ready low for 4 cycles.
- R8: A PUSH or CALL while sp <= lim_lo, or an ENTER with sp-1-size < lim_lo, is refused. A refused command writes no memory, leaves sp, fp and next_pc unchanged, keeps cmd_ready high and sets err.
- R9: A POP while sp >= lim_hi, a LEAVE while fp >= lim_hi, or a RET while fp+1 >= lim_hi is refused. It issues no memory request, leaves sp, fp, next_pc and pop_data unchanged and sets err.
- R10: Once set, err stays set through any later commands until reset.
- R11: The unit issues memory requests only while cmd_ready is low, and cmd_ready is low for the whole sequence of every accepted command.
- R12: cmd_op codes 6 and 7 are accepted with cmd_ready staying high. They have no effect on sp, fp, next_pc, err or memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle and able to take a command |
| cmd_op | input | 3 | Command code |
| cmd_a | input | DW | Push data, call target or enter size |
| cmd_b | input | DW | Return address for call |
| lim_lo | input | AW | Lowest address the stack may occupy |
| lim_hi | input | AW | Address just above the stack's highest word |
| sp | output | AW | Stack pointer |
| fp | output | AW | Frame pointer |
| next_pc | output | DW | Next program counter from call or return |
| pop_data | output | DW | Last popped word |
| err | output | 1 | Sticky limit violation flag |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write when set, read otherwise |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid the cycle after a read |

## Verification
The assertions check the following on every cycle: each memory write is followed by sp landing on the written address, a pop's capture step advances sp by one, memory is touched only while ready is low, an accepted valid command drops ready, and a refused command leaves the pointers and memory alone while raising the sticky flag. What these checks cannot show is whether a frame links correctly, that is, whether nested call/enter pairs unwound by leave and return bring back the right frame pointers and return addresses. Only the bench scenarios show this, by comparing against a behavioural model of the stack and its memory. The same holds for the exact busy length of each command and for the boundary arithmetic of the enter limit check.

// File: rtl/frame_stack_pkg.sv
package frame_stack_pkg;

    typedef enum logic [2:0] {
        OP_PUSH  = 3'd0,
        OP_POP   = 3'd1,
        OP_CALL  = 3'd2,
        OP_ENTER = 3'd3,
        OP_LEAVE = 3'd4,
        OP_RET   = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR,
        ST_FRAME,
        ST_RD,
        ST_CAP,
        ST_LRD,
        ST_LCAP
    } st_e;

    function automatic logic op_known(input op_e op);
        return (op != OP_RSV6) && (op != OP_RSV7);
    endfunction

    function automatic st_e first_step(input op_e op);
        case (op)
            OP_PUSH, OP_CALL, OP_ENTER: return ST_WR;
            OP_POP:                     return ST_RD;
            OP_LEAVE, OP_RET:           return ST_LRD;
            default:                    return ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/frame_stack_guard.sv
module frame_stack_guard
    import frame_stack_pkg::*;
#(
    parameter int AW = 8
) (
    input  op_e           op,
    input  logic [AW-1:0] sp,
    input  logic [AW-1:0] fp,
    input  logic [AW-1:0] size,
    input  logic [AW-1:0] lim_lo,
    input  logic [AW-1:0] lim_hi,
    output logic          reject
);
    localparam int XW = AW + 1;

    logic [XW-1:0] x_sp, x_fp, x_lo, x_hi, x_size;

    always_comb begin
        x_sp   = {1'b0, sp};
        x_fp   = {1'b0, fp};
        x_lo   = {1'b0, lim_lo};
        x_hi   = {1'b0, lim_hi};
        x_size = {1'b0, size};
        case (op)
            OP_PUSH, OP_CALL: reject = (x_sp <= x_lo);
            OP_ENTER:         reject = (x_sp < (x_lo + XW'(1) + x_size));
            OP_POP:           reject = (x_sp >= x_hi);
            OP_LEAVE:         reject = (x_fp >= x_hi);
            OP_RET:           reject = ((x_fp + XW'(1)) >= x_hi);
            default:          reject = 1'b0;
        endcase
    end

endmodule

// File: rtl/frame_stack_ctrl.sv
module frame_stack_ctrl
    import frame_stack_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_valid,
    input  op_e  cmd_op,
    input  logic reject,
    output st_e  state,
    output op_e  op_q,
    output logic ready
);
    st_e  nxt;
    logic go;

    assign ready = (state == ST_IDLE);
    assign go    = cmd_valid && ready && !reject && op_known(cmd_op);

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  nxt = go ? first_step(cmd_op) : ST_IDLE;
            ST_WR:    nxt = (op_q == OP_ENTER) ? ST_FRAME : ST_IDLE;
            ST_FRAME: nxt = ST_IDLE;
            ST_RD:    nxt = ST_CAP;
            ST_CAP:   nxt = ST_IDLE;
            ST_LRD:   nxt = ST_LCAP;
            ST_LCAP:  nxt = (op_q == OP_RET) ? ST_RD : ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            op_q  <= OP_PUSH;
        end else begin
            state <= nxt;
            if (go) op_q <= cmd_op;
        end
    end

    // R11: an accepted, allowed command leaves the idle state at once
    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && ready && !reject && op_known(cmd_op)) |=> !ready);

    // R12: reserved codes keep the unit idle
    a_r12_reserved_idle: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && ready && !op_known(cmd_op)) |=> ready);

endmodule

// File: rtl/frame_stack_unit.sv
module frame_stack_unit
    import frame_stack_pkg::*;
#(
    parameter int AW  = 8,
    parameter int DW  = 16,
    parameter int TOP = 240
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [2:0]    cmd_op,
    input  logic [DW-1:0] cmd_a,
    input  logic [DW-1:0] cmd_b,
    input  logic [AW-1:0] lim_lo,
    input  logic [AW-1:0] lim_hi,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] fp,
    output logic [DW-1:0] next_pc,
    output logic [DW-1:0] pop_data,
    output logic          err,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    localparam logic [AW-1:0] TOP_A = AW'(TOP);

    op_e           op_in, op_q;
    st_e           st;
    logic          reject, accept;
    logic [DW-1:0] arg_q, wdat_q;

    assign op_in  = op_e'(cmd_op);
    assign accept = cmd_valid && cmd_ready;

    frame_stack_guard #(.AW(AW)) u_guard (
        .op     (op_in),
        .sp     (sp),
        .fp     (fp),
        .size   (cmd_a[AW-1:0]),
        .lim_lo (lim_lo),
        .lim_hi (lim_hi),
        .reject (reject)
    );

    frame_stack_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (op_in),
        .reject    (reject),
        .state     (st),
        .op_q      (op_q),
        .ready     (cmd_ready)
    );

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = sp;
        mem_wdata = wdat_q;
        case (st)
            ST_WR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = sp - 1'b1;
            end
            ST_RD:   mem_req = 1'b1;
            ST_LRD: begin
                mem_req  = 1'b1;
                mem_addr = fp;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp       <= TOP_A;
            fp       <= TOP_A;
            next_pc  <= '0;
            pop_data <= '0;
            err      <= 1'b0;
            arg_q    <= '0;
            wdat_q   <= '0;
        end else begin
            if (accept) begin
                arg_q <= cmd_a;
                case (op_in)
                    OP_PUSH: wdat_q <= cmd_a;
                    OP_CALL: wdat_q <= cmd_b;
                    default: wdat_q <= DW'(fp);
                endcase
                if (reject) err <= 1'b1;
            end
            case (st)
                ST_WR: begin
                    sp <= sp - 1'b1;
                    if (op_q == OP_CALL) next_pc <= arg_q;
                end
                ST_FRAME: begin
                    fp <= sp;
                    sp <= sp - arg_q[AW-1:0];
                end
                ST_CAP: begin
                    if (op_q == OP_POP) pop_data <= mem_rdata;
                    else                next_pc  <= mem_rdata;
                    sp <= sp + 1'b1;
                end
                ST_LCAP: begin
                    fp <= mem_rdata[AW-1:0];
                    sp <= fp + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R11: memory is touched only inside a running sequence
    a_r11_mem_only_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !cmd_ready);

    // R2: every write goes to the slot sp moves onto (pre-decrement)
    a_r2_write_predec: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |=> (sp == $past(mem_addr)));

    // R3: the capture step of a pop advances sp by one word
    a_r3_pop_postinc: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CAP) |=> (sp == $past(sp) + 1'b1));

    // R8: a refused command changes no pointer, touches no memory, raises err
    a_r8_reject_no_change: assert property (@(posedge clk) disable iff (rst)
        (accept && reject) |=> (!mem_req && $stable(sp) && $stable(fp) && err));

    // R10: the error flag is sticky
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

endmodule

// File: tb/frame_stack_unit_test.sv
module frame_stack_unit_test;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int TOPV = 240;

    localparam int C_PUSH = 0, C_POP = 1, C_CALL = 2, C_ENTER = 3, C_LEAVE = 4, C_RET = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [2:0]    cmd_op = '0;
    logic [DW-1:0] cmd_a = '0, cmd_b = '0;
    logic [AW-1:0] lim_lo = 8'h10, lim_hi = 8'hF0;
    logic [AW-1:0] sp, fp, mem_addr;
    logic [DW-1:0] next_pc, pop_data, mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          err, mem_req, mem_we;

    int checks = 0;
    int failures = 0;

    logic [DW-1:0] ram [256];
    int m_mem [256];
    int m_sp, m_fp, m_pc, m_pop, m_err;

    always #2.5 clk = ~clk;

    frame_stack_unit #(.AW(AW), .DW(DW), .TOP(TOPV)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_a(cmd_a), .cmd_b(cmd_b), .lim_lo(lim_lo), .lim_hi(lim_hi),
        .sp(sp), .fp(fp), .next_pc(next_pc), .pop_data(pop_data), .err(err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else        mem_rdata <= ram[mem_addr];
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        int bad = 0;
        chk(req, "sp", int'(sp), m_sp);
        chk(req, "fp", int'(fp), m_fp);
        chk(req, "next_pc", int'(next_pc), m_pc);
        chk(req, "pop_data", int'(pop_data), m_pop);
        chk(req, "err", int'(err), m_err);
        for (int i = 0; i < 256; i++) if (int'(ram[i]) != m_mem[i]) bad++;
        chk(req, "memory mismatches", bad, 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_sp = TOPV; m_fp = TOPV; m_pc = 0; m_pop = 0; m_err = 0;
        @(negedge clk);
    endtask

    task automatic do_cmd(input int op, input int a, input int b, input string req);
        int lo = int'(lim_lo);
        int hi = int'(lim_hi);
        int sz = a & 255;
        int exp_busy = 0;
        int busy = 0;
        bit rej = 1'b0;
        case (op)
            C_PUSH: if (m_sp <= lo) rej = 1; else begin m_sp--; m_mem[m_sp] = a; exp_busy = 1; end
            C_POP:  if (m_sp >= hi) rej = 1; else begin m_pop = m_mem[m_sp]; m_sp++; exp_busy = 2; end
            C_CALL: if (m_sp <= lo) rej = 1; else begin m_sp--; m_mem[m_sp] = b; m_pc = a; exp_busy = 1; end
            C_ENTER: if (m_sp - 1 - sz < lo) rej = 1;
                     else begin m_sp--; m_mem[m_sp] = m_fp; m_fp = m_sp; m_sp -= sz; exp_busy = 2; end
            C_LEAVE: if (m_fp >= hi) rej = 1;
                     else begin m_sp = m_fp + 1; m_fp = m_mem[m_fp] & 255; exp_busy = 2; end
            C_RET:   if (m_fp + 1 >= hi) rej = 1;
                     else begin m_sp = m_fp + 1; m_fp = m_mem[m_fp] & 255;
                                m_pc = m_mem[m_sp]; m_sp++; exp_busy = 4; end
            default: ;
        endcase
        if (rej) m_err = 1;
        chk("R11", "ready before command", int'(cmd_ready), 1);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_a = DW'(a); cmd_b = DW'(b);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!cmd_ready && busy < 10) begin
            busy++;
            @(negedge clk);
        end
        chk(req, "busy cycles", busy, exp_busy);
        compare_all(req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin ram[i] = '0; m_mem[i] = 0; end
        do_reset();
        // R1: reset state
        chk("R1", "ready", int'(cmd_ready), 1);
        compare_all("R1");

        // R2 / R3: pushes then pops in LIFO order
        do_cmd(C_PUSH, 16'h1111, 0, "R2");
        do_cmd(C_PUSH, 16'h2222, 0, "R2");
        do_cmd(C_PUSH, 16'h3333, 0, "R2");
        do_cmd(C_POP, 0, 0, "R3");
        do_cmd(C_POP, 0, 0, "R3");
        do_cmd(C_PUSH, 16'h4444, 0, "R2");
        do_cmd(C_POP, 0, 0, "R3");
        do_cmd(C_POP, 0, 0, "R3");

        // R9: pop on an empty stack, leave and ret without a frame
        do_cmd(C_POP, 0, 0, "R9");
        do_cmd(C_LEAVE, 0, 0, "R9");
        do_cmd(C_RET, 0, 0, "R9");

        // R4 / R5: nested call and enter frames
        do_cmd(C_CALL, 16'h0100, 16'h0011, "R4");
        do_cmd(C_ENTER, 3, 0, "R5");
        do_cmd(C_PUSH, 16'hABCD, 0, "R2");
        do_cmd(C_CALL, 16'h0200, 16'h0022, "R4");
        do_cmd(C_ENTER, 2, 0, "R5");
        do_cmd(C_CALL, 16'h0300, 16'h0033, "R4");
        do_cmd(C_ENTER, 0, 0, "R5");
        // R7: unwind the innermost two frames by return
        do_cmd(C_RET, 0, 0, "R7");
        do_cmd(C_RET, 0, 0, "R7");
        // R6: leave then pop of the return address
        do_cmd(C_LEAVE, 0, 0, "R6");
        do_cmd(C_POP, 0, 0, "R6");
        // R10: err still set after good commands
        chk("R10", "err sticky", int'(err), 1);

        // R12: reserved codes
        do_cmd(6, 16'h5555, 16'h6666, "R12");
        do_cmd(7, 16'h7777, 16'h0001, "R12");

        // R8: lower-limit refusals
        do_reset();
        chk("R10", "err cleared by reset", int'(err), 0);
        lim_lo = 8'hEE;
        do_cmd(C_ENTER, 1, 0, "R5");
        do_cmd(C_PUSH, 16'h0009, 0, "R8");
        do_cmd(C_CALL, 16'h0400, 16'h0044, "R8");
        do_cmd(C_LEAVE, 0, 0, "R6");
        do_cmd(C_ENTER, 2, 0, "R8");
        do_cmd(C_ENTER, 1, 0, "R5");
        do_cmd(C_POP, 0, 0, "R3");
        do_cmd(C_POP, 0, 0, "R3");
        lim_lo = 8'h10;
        do_cmd(C_RET, 0, 0, "R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule